// File: doc/BRIEF.md
# Serial Burst Register Access Slave

This block is a serial-peripheral slave that gives a host read and write access to a 256-location register address space. Only part of that space holds storage. A frame starts when chip select falls and ends when it rises. Each frame carries a command byte, then a register address byte, then data bytes. With the burst flag set, the address steps after every data byte, so a single header can walk through any run of locations. The run wraps from the top of the space back to the bottom.

All serial pins are sampled in a faster system clock through two-flop synchronizers. Clock edges are detected in that domain. A small state machine walks the frame through the states IDLE, CMD, ADDR, DATA and DRAIN:
- IDLE → CMD when chip select becomes active.
- CMD → ADDR after eight bits.
- ADDR → DATA after eight bits.
- DATA → DATA after each byte of a burst frame.
- DATA → DRAIN after the single byte of a non-burst frame.
- Any state → IDLE when chip select goes inactive.

Register 0x00 holds a broadcast policy. The policy decides whether a burst write is accepted, by comparing the device field of the command byte against a strapped channel ID, against zero, or against neither.

Top module: `spi_burst_regslave`

## Requirements
- R1: The bus uses mode 0 with MSB first. MOSI is taken on rising SCLK and MISO changes after falling SCLK. Each frame sends a command byte and then an address byte. In the command byte, bit 7 = 1 means read, bit 6 = 1 means burst, bits 5..2 are the device field C6..C3, and bits 1..0 are ignored.
- R2: A read returns the stored byte of the addressed register on MISO, MSB first, in the byte that follows the address byte. A write stores the byte that follows the address byte.
- R3: In a burst frame, the address goes up by one after each complete data byte, for reads and for writes. The frame lasts as long as chip select is held low.
- R4: After address 0xFF the address continues at 0x00.
- R5: Implemented addresses are 0x00..LO_COUNT-1 and HI_BASE..0xFF (by default 0x00..0x0F and 0xF8..0xFF). Every other address is a hole. Reading a hole gives 0x00. A byte written to a hole is discarded, and the address still advances.
- R6: In a non-burst frame, only the first data byte is transferred. Later write bytes change nothing, and later read bytes return 0x00.
- R7: After reset, every register is 0x00 and the policy bits are clear. In that state a burst write is accepted with any device field.
- R8: When bit 1 of register 0x00 is set, a burst write is accepted only if the device field equals chan_id. Non-burst writes are never filtered.
- R9: When bit 3 of register 0x00 is set, a burst write is accepted only if the device field is 0. When both bits are set, either match is enough.
- R10: If chip select rises before a byte is complete, the partial byte is dropped and no register is written.
- R11: MISO is 0 while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| mosi | input | 1 | Serial data from the host |
| chan_id | input | 4 | Strapped channel identity of this device |
| miso | output | 1 | Serial data to the host |

## Verification
The bench targets address wrap from 0xFF to 0x00. A design that saturates, or that fails to wrap, would read back 0x00 where the wrapped bytes belong. Bursts that cross holes show whether a design stalls or skips the address at a hole; such a design would put later bytes into the wrong registers. Non-burst frames with trailing bytes, and frames cut off mid-byte, expose a slave that keeps writing after its single byte or commits a half-shifted byte. Each policy setting is tried with a matching and a non-matching device field, so an inverted or missing filter shows up as a stored or missing value.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_DRAIN = 3'd4
    } frame_st_e;

    localparam int CMD_RNW_BIT   = 7;
    localparam int CMD_BURST_BIT = 6;
    localparam int CMD_DEV_MSB   = 5;
    localparam int CMD_DEV_LSB   = 2;
    localparam int POL_CHAN_BIT  = 1;
    localparam int POL_ZERO_BIT  = 3;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_burst_regfile.sv
module spi_burst_regfile #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int LO_COUNT = 16,
    parameter int HI_BASE  = 248
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pol_chan,
    output logic          pol_zero
);
    import spi_burst_pkg::*;

    localparam int SPACE    = 1 << AW;
    localparam int HI_COUNT = SPACE - HI_BASE;
    localparam int DEPTH    = LO_COUNT + HI_COUNT;
    localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] regs_q [DEPTH];

    function automatic logic is_impl(input logic [AW-1:0] a);
        return (int'(a) < LO_COUNT) || (int'(a) >= HI_BASE);
    endfunction

    function automatic logic [IW-1:0] slot_of(input logic [AW-1:0] a);
        int s;
        if (int'(a) < LO_COUNT) s = int'(a);
        else                    s = int'(a) - HI_BASE + LO_COUNT;
        return IW'(s);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en && is_impl(wr_addr)) begin
            regs_q[slot_of(wr_addr)] <= wr_data;
        end
    end

    always_comb begin
        if (is_impl(rd_addr)) rd_data = regs_q[slot_of(rd_addr)];
        else                  rd_data = '0;
    end

    assign pol_chan = regs_q[0][POL_CHAN_BIT];
    assign pol_zero = regs_q[0][POL_ZERO_BIT];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm #(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int DEV = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_act,
    input  logic                       sclk_rise,
    input  logic                       sclk_fall,
    input  logic                       mosi_s,
    input  logic [DEV-1:0]             chan_id,
    input  logic                       pol_chan,
    input  logic                       pol_zero,
    input  logic [DW-1:0]              rd_data,
    output logic [AW-1:0]              rd_addr,
    output logic                       wr_en,
    output logic [AW-1:0]              wr_addr,
    output logic [DW-1:0]              wr_data,
    output logic                       miso_o,
    output logic [AW-1:0]              cur_addr,
    output logic                       data_done,
    output spi_burst_pkg::frame_st_e   state
);
    import spi_burst_pkg::*;

    localparam int BW = $clog2(DW);

    frame_st_e      st_q, st_d;
    logic [BW-1:0]  bit_q;
    logic [DW-1:0]  rx_q, rx_next, tx_q;
    logic [AW-1:0]  addr_q;
    logic           rnw_q, burst_q, accept_q, miso_q;
    logic           active, byte_done;
    logic [DEV-1:0] dev_f;

    assign active    = cs_act && (st_q != ST_IDLE);
    assign rx_next   = {rx_q[DW-2:0], mosi_s};
    assign byte_done = active && sclk_rise && (bit_q == BW'(DW-1));
    assign dev_f     = rx_next[CMD_DEV_MSB:CMD_DEV_LSB];

    function automatic logic policy_ok(input logic [DEV-1:0] d, input logic pc,
                                       input logic pz, input logic [DEV-1:0] own);
        if (!pc && !pz) return 1'b1;
        return (pc && (d == own)) || (pz && (d == '0));
    endfunction

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!cs_act) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_CMD;
                ST_CMD:   if (byte_done) st_d = ST_ADDR;
                ST_ADDR:  if (byte_done) st_d = ST_DATA;
                ST_DATA:  if (byte_done && !burst_q) st_d = ST_DRAIN;
                ST_DRAIN: st_d = ST_DRAIN;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            miso_q   <= 1'b0;
            addr_q   <= '0;
            rnw_q    <= 1'b0;
            burst_q  <= 1'b0;
            accept_q <= 1'b0;
        end else if (!cs_act) begin
            bit_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else begin
            if (active && sclk_rise) begin
                rx_q  <= rx_next;
                bit_q <= bit_q + 1'b1;
            end
            if (active && sclk_fall) begin
                miso_q <= tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
            end
            if (byte_done) begin
                unique case (st_q)
                    ST_CMD: begin
                        rnw_q    <= rx_next[CMD_RNW_BIT];
                        burst_q  <= rx_next[CMD_BURST_BIT];
                        accept_q <= rx_next[CMD_RNW_BIT] || !rx_next[CMD_BURST_BIT]
                                    || policy_ok(dev_f, pol_chan, pol_zero, chan_id);
                    end
                    ST_ADDR: begin
                        addr_q <= rx_next[AW-1:0];
                        tx_q   <= rnw_q ? rd_data : '0;
                    end
                    ST_DATA: begin
                        addr_q <= addr_q + 1'b1;
                        tx_q   <= (rnw_q && burst_q) ? rd_data : '0;
                    end
                    default: tx_q <= '0;
                endcase
            end
        end
    end

    assign rd_addr   = (st_q == ST_ADDR) ? rx_next[AW-1:0] : addr_q + 1'b1;
    assign data_done = byte_done && (st_q == ST_DATA);
    assign wr_en     = data_done && !rnw_q && accept_q;
    assign wr_addr   = addr_q;
    assign wr_data   = rx_next;
    assign miso_o    = miso_q;
    assign cur_addr  = addr_q;
    assign state     = st_q;
endmodule

// File: rtl/spi_burst_regslave.sv
module spi_burst_regslave #(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int DEV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LO_COUNT    = 16,
    parameter int HI_BASE     = 248
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           mosi,
    input  logic [DEV-1:0] chan_id,
    output logic           miso
);
    import spi_burst_pkg::*;

    logic sclk_s, cs_n_s, mosi_s, sclk_prev_q;
    logic sclk_rise, sclk_fall, cs_act;
    logic wr_en, data_done, pol_chan, pol_zero;
    logic [AW-1:0] rd_addr, wr_addr, cur_addr;
    logic [DW-1:0] rd_data, wr_data;
    frame_st_e fsm_state;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_n_s));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev_q;
    assign sclk_fall = !sclk_s && sclk_prev_q;
    assign cs_act    = !cs_n_s;

    spi_frame_fsm #(.AW(AW), .DW(DW), .DEV(DEV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .chan_id(chan_id), .pol_chan(pol_chan), .pol_zero(pol_zero),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .miso_o(miso),
        .cur_addr(cur_addr), .data_done(data_done), .state(fsm_state));

    spi_burst_regfile #(.AW(AW), .DW(DW), .LO_COUNT(LO_COUNT), .HI_BASE(HI_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pol_chan(pol_chan), .pol_zero(pol_zero));
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
    parameter int AW = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_act,
    input logic                     data_done,
    input logic [AW-1:0]            addr,
    input logic                     miso,
    input logic                     wr_en,
    input spi_burst_pkg::frame_st_e state
);
    import spi_burst_pkg::*;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> addr == $past(addr) + 1'b1); // R3

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && addr == {AW{1'b1}}) |=> addr == '0); // R4

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == ST_IDLE); // R10

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso); // R11

    AST_DRAIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAIN |-> !wr_en); // R6
endmodule

bind spi_burst_regslave spi_burst_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .data_done(data_done),
    .addr(cur_addr), .miso(miso), .wr_en(wr_en), .state(fsm_state));

// File: tb/test_spi_burst_regslave.sv
module test_spi_burst_regslave;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 8;
    localparam int  WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic [3:0] chan_id = 4'd5;
    logic miso;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] txb [0:7];
    logic [7:0] rxb [0:7];

    spi_burst_regslave i_spi_burst_regslave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .chan_id(chan_id), .miso(miso));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] cmd_of(input logic rd, input logic bst, input logic [3:0] dev);
        return {rd, bst, dev, 2'b00};
    endfunction

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nb; i++) begin
            mosi = tx[7-i];
            repeat (HALF) @(negedge clk);
            rx[7-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [7:0] adr,
                         input int nbytes, input int tail_bits);
        logic [7:0] junk;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        xfer(cmd, 8, junk);
        xfer(adr, 8, junk);
        for (int k = 0; k < nbytes; k++) xfer(txb[k], 8, rxb[k]);
        if (tail_bits > 0) xfer(txb[nbytes], tail_bits, junk);
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr1(input logic [7:0] adr, input logic [7:0] v, input logic [3:0] dev);
        txb[0] = v;
        frame(cmd_of(1'b0, 1'b0, dev), adr, 1, 0);
    endtask

    task automatic rd1(input logic [7:0] adr, output logic [7:0] v);
        frame(cmd_of(1'b1, 1'b0, 4'd0), adr, 1, 0);
        v = rxb[0];
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 miso idle", {7'd0, miso}, 8'h00);
        rd1(8'h00, v); chk("R7 reg00 reset", v, 8'h00);
        rd1(8'hFF, v); chk("R7 regFF reset", v, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] v;
        wr1(8'h05, 8'hA5, 4'd0);
        rd1(8'h05, v); chk("R2 single rw 05", v, 8'hA5);
        wr1(8'h0D, 8'h3C, 4'd0);
        rd1(8'h0D, v); chk("R1 R2 single rw 0D", v, 8'h3C);
    endtask

    task automatic t_drain();
        logic [7:0] v;
        txb[0] = 8'h31; txb[1] = 8'h32; txb[2] = 8'h33;
        frame(cmd_of(1'b0, 1'b0, 4'd0), 8'h03, 3, 0);
        rd1(8'h03, v); chk("R6 first byte stored", v, 8'h31);
        rd1(8'h04, v); chk("R6 extra byte ignored", v, 8'h00);
        frame(cmd_of(1'b1, 1'b0, 4'd0), 8'h05, 2, 0);
        chk("R6 read byte0", rxb[0], 8'hA5);
        chk("R6 read byte1 zero", rxb[1], 8'h00);
    endtask

    task automatic t_burst();
        for (int k = 0; k < 4; k++) txb[k] = 8'h12 + 8'(k);
        frame(cmd_of(1'b0, 1'b1, 4'd7), 8'h02, 4, 0);
        frame(cmd_of(1'b1, 1'b1, 4'd0), 8'h02, 4, 0);
        for (int k = 0; k < 4; k++) chk("R3 R7 burst readback", rxb[k], 8'h12 + 8'(k));
    endtask

    task automatic t_wrap();
        txb[0] = 8'hC1; txb[1] = 8'hC2; txb[2] = 8'h00; txb[3] = 8'hC4;
        frame(cmd_of(1'b0, 1'b1, 4'd0), 8'hFE, 4, 0);
        frame(cmd_of(1'b1, 1'b1, 4'd0), 8'hFD, 5, 0);
        chk("R4 wrap FD", rxb[0], 8'h00);
        chk("R4 wrap FE", rxb[1], 8'hC1);
        chk("R4 wrap FF", rxb[2], 8'hC2);
        chk("R4 wrap 00", rxb[3], 8'h00);
        chk("R4 wrap 01", rxb[4], 8'hC4);
    endtask

    task automatic t_holes();
        logic [7:0] v;
        txb[0] = 8'h7E; txb[1] = 8'h7F; txb[2] = 8'hAA; txb[3] = 8'hBB;
        frame(cmd_of(1'b0, 1'b1, 4'd0), 8'h0E, 4, 0);
        frame(cmd_of(1'b1, 1'b1, 4'd0), 8'h0E, 4, 0);
        chk("R5 lo 0E", rxb[0], 8'h7E);
        chk("R5 lo 0F", rxb[1], 8'h7F);
        chk("R5 hole 10", rxb[2], 8'h00);
        chk("R5 hole 11", rxb[3], 8'h00);
        txb[0] = 8'h99; txb[1] = 8'h5A;
        frame(cmd_of(1'b0, 1'b1, 4'd0), 8'hF7, 2, 0);
        rd1(8'hF7, v); chk("R5 hole F7", v, 8'h00);
        rd1(8'hF8, v); chk("R5 advance past hole F8", v, 8'h5A);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        txb[0] = 8'hE7;
        frame(cmd_of(1'b0, 1'b0, 4'd0), 8'h0A, 0, 4);
        rd1(8'h0A, v); chk("R10 partial single", v, 8'h00);
        txb[0] = 8'h21; txb[1] = 8'hF0;
        frame(cmd_of(1'b0, 1'b1, 4'd0), 8'h0B, 1, 5);
        rd1(8'h0B, v); chk("R10 full byte kept", v, 8'h21);
        rd1(8'h0C, v); chk("R10 partial burst", v, 8'h00);
    endtask

    task automatic bw1(input logic [7:0] adr, input logic [7:0] v, input logic [3:0] dev);
        txb[0] = v;
        frame(cmd_of(1'b0, 1'b1, dev), adr, 1, 0);
    endtask

    task automatic t_filter();
        logic [7:0] v;
        wr1(8'h00, 8'h02, 4'd9);
        bw1(8'h06, 8'h11, 4'd3);
        rd1(8'h06, v); chk("R8 chan mismatch rejected", v, 8'h00);
        bw1(8'h06, 8'h22, 4'd5);
        rd1(8'h06, v); chk("R8 chan match accepted", v, 8'h22);
        wr1(8'h00, 8'h08, 4'd9);
        bw1(8'h07, 8'h33, 4'd5);
        rd1(8'h07, v); chk("R9 nonzero rejected", v, 8'h00);
        bw1(8'h07, 8'h44, 4'd0);
        rd1(8'h07, v); chk("R9 zero accepted", v, 8'h44);
        wr1(8'h00, 8'h0A, 4'd9);
        bw1(8'h08, 8'h55, 4'd5);
        rd1(8'h08, v); chk("R9 both chan accepted", v, 8'h55);
        bw1(8'h09, 8'h66, 4'd9);
        rd1(8'h09, v); chk("R9 both other rejected", v, 8'h00);
        wr1(8'h09, 8'h77, 4'd9);
        rd1(8'h09, v); chk("R8 single unfiltered", v, 8'h77);
        wr1(8'h00, 8'h00, 4'd0);
        chk("R11 miso idle end", {7'd0, miso}, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single();
        t_drain();
        t_burst();
        t_wrap();
        t_holes();
        t_abort();
        t_filter();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule